// File: doc/BRIEF.md
# Compact Subtract and Test Unit

This unit executes five 16-bit instructions. Three of them subtract and write a low register. One lowers the stack pointer by a word-scaled immediate. One ANDs two registers only to set the condition flags. The register file delivers the values of the source operands, the stack pointer and the current flags beside the instruction word. The unit returns a result word, the destination to write, separate write enables for the register and the flags, and the next flag value.

A single register stage sits between the inputs and the outputs. An instruction accepted with `in_valid` high appears on the outputs one clock later. In a cycle without a valid instruction the enables drop to zero. An instruction word that matches none of the five encodings is accepted but writes nothing.

Top module: `stu_core`

## Requirements
- R1: Instruction bits [15:9] = 0001111 gives result = rn_val − bits[8:6] (zero-extended, 0 to 7), written to the low register named by bits[2:0], and flags are written.
- R2: Instruction bits [15:11] = 00111 gives result = rd_val − bits[7:0] (0 to 255), written to the low register named by bits[10:8], and flags are written.
- R3: Instruction bits [15:9] = 0001101 gives result = rn_val − rm_val, written to the low register named by bits[2:0], and flags are written.
- R4: Flags are packed as flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V. When flags are written, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R5: For the subtract forms, C is 1 when no borrow occurs, that is, when the minuend is unsigned-greater-or-equal to the subtrahend.
- R6: For the subtract forms, V is 1 when the two's-complement difference overflows. This happens when the operand signs differ and the result sign differs from the minuend.
- R7: Instruction bits [15:7] = 101100001 gives result = sp_val − (bits[6:0] × 4), with dst_sp = 1 and reg_we = 1. flag_we = 0 and flags_out equals flags_in.
- R8: Instruction bits [15:6] = 0100001000 gives result = rn_val AND rm_val, with reg_we = 0 and flag_we = 1. N and Z follow the AND result, and C and V are copied from flags_in.
- R9: An instruction word that matches none of the encodings above gives reg_we = 0, flag_we = 0 and flags_out = flags_in. A cycle with in_valid = 0 gives reg_we = 0 and flag_we = 0.
- R10: While rst_n is low, all outputs are zero.
- R11: Outputs reflect the instruction accepted at the previous rising clock edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 16 | Instruction word |
| rn_val | input | 32 | Value of the first source register |
| rm_val | input | 32 | Value of the second source register |
| rd_val | input | 32 | Value of the destination register (minuend of the 8-bit immediate form) |
| sp_val | input | 32 | Current stack pointer |
| flags_in | input | 4 | Current flags, N Z C V from bit 3 down |
| res | output | 32 | Result word |
| dst_sp | output | 1 | 1 = write the stack pointer, 0 = write a low register |
| dst_idx | output | 3 | Low register index to write |
| reg_we | output | 1 | Register write enable |
| flag_we | output | 1 | Flag write enable |
| flags_out | output | 4 | Next flag value |

## Verification
The subtract forms raise the register write and the flag write in the same cycle. The flag word and the result both come from one adder, so a fault in either appears as a mismatch between the two. The bench provokes this with 0 − 0 and with the signed-boundary operands 0x80000000 − 1 and 0x7FFFFFFF − 0xFFFFFFFF. These cases raise Z, C or V together with a written result. Every output is judged against a reference that works out the borrow from a 33-bit difference and the overflow from a 64-bit signed difference. The stack-pointer and test forms each raise only one enable, and the bench confirms that the other enable stays low and that the untouched flags pass through.

// File: rtl/stu_pkg.sv
package stu_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SUB_I3 = 3'd1,
    OP_SUB_I8 = 3'd2,
    OP_SUB_RR = 3'd3,
    OP_SP_DEC = 3'd4,
    OP_TEST   = 3'd5
  } stu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } stu_flags_t;

  localparam int INSN_W = 16;
  localparam int RIDX_W = 3;
  localparam int FLAG_W = 4;

endpackage

// File: rtl/stu_decode.sv
module stu_decode
  import stu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSN_W-1:0] instr,
  output stu_op_e           op,
  output logic [RIDX_W-1:0] dst_idx,
  output logic [DATA_W-1:0] imm
);

  localparam int IMM7_SH = 2;

  always_comb begin
    op      = OP_NONE;
    dst_idx = instr[2:0];
    imm     = '0;
    if (instr[15:9] == 7'b0001111) begin
      op  = OP_SUB_I3;
      imm = DATA_W'(instr[8:6]);
    end else if (instr[15:9] == 7'b0001101) begin
      op  = OP_SUB_RR;
    end else if (instr[15:11] == 5'b00111) begin
      op      = OP_SUB_I8;
      dst_idx = instr[10:8];
      imm     = DATA_W'(instr[7:0]);
    end else if (instr[15:7] == 9'b101100001) begin
      op  = OP_SP_DEC;
      imm = DATA_W'({instr[6:0], {IMM7_SH{1'b0}}});
    end else if (instr[15:6] == 10'b0100001000) begin
      op  = OP_TEST;
    end
  end

endmodule

// File: rtl/stu_opsel.sv
module stu_opsel
  import stu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  stu_op_e           op,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] rd_val,
  input  logic [DATA_W-1:0] sp_val,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] minuend,
  output logic [DATA_W-1:0] subtrahend
);

  always_comb begin
    unique case (op)
      OP_SUB_I3: begin minuend = rn_val; subtrahend = imm;    end
      OP_SUB_I8: begin minuend = rd_val; subtrahend = imm;    end
      OP_SUB_RR: begin minuend = rn_val; subtrahend = rm_val; end
      OP_SP_DEC: begin minuend = sp_val; subtrahend = imm;    end
      default:   begin minuend = rn_val; subtrahend = rm_val; end
    endcase
  end

endmodule

// File: rtl/stu_alu.sv
module stu_alu
  import stu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  stu_op_e           op,
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] rm_val,
  input  stu_flags_t        flags_in,
  output logic [DATA_W-1:0] result,
  output stu_flags_t        flags_nx,
  output logic              wr_reg,
  output logic              wr_flags,
  output logic              to_sp,
  output logic              sub_carry,
  output logic              sub_ovf
);

  localparam int MSB = DATA_W - 1;

  // minuend + ~subtrahend + 1, widened by one bit to keep the carry-out
  function automatic logic [DATA_W:0] sub_wide(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic ovf_of(input logic [DATA_W-1:0] a,
                                  input logic [DATA_W-1:0] b,
                                  input logic [DATA_W-1:0] d);
    return (a[MSB] != b[MSB]) && (d[MSB] != a[MSB]);
  endfunction

  logic [DATA_W:0]   diff_w;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] and_v;

  assign diff_w    = sub_wide(minuend, subtrahend);
  assign diff      = diff_w[DATA_W-1:0];
  assign sub_carry = diff_w[DATA_W];
  assign sub_ovf   = ovf_of(minuend, subtrahend, diff);
  assign and_v     = rn_val & rm_val;

  always_comb begin
    result   = '0;
    flags_nx = flags_in;
    wr_reg   = 1'b0;
    wr_flags = 1'b0;
    to_sp    = 1'b0;
    unique case (op)
      OP_SUB_I3, OP_SUB_I8, OP_SUB_RR: begin
        result   = diff;
        wr_reg   = 1'b1;
        wr_flags = 1'b1;
        flags_nx = '{n: diff[MSB], z: (diff == '0), c: sub_carry, v: sub_ovf};
      end
      OP_SP_DEC: begin
        result = diff;
        wr_reg = 1'b1;
        to_sp  = 1'b1;
      end
      OP_TEST: begin
        result   = and_v;
        wr_flags = 1'b1;
        flags_nx = '{n: and_v[MSB], z: (and_v == '0), c: flags_in.c, v: flags_in.v};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/stu_core.sv
module stu_core
  import stu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [INSN_W-1:0]   instr,
  input  logic [DATA_W-1:0]   rn_val,
  input  logic [DATA_W-1:0]   rm_val,
  input  logic [DATA_W-1:0]   rd_val,
  input  logic [DATA_W-1:0]   sp_val,
  input  logic [FLAG_W-1:0]   flags_in,
  output logic [DATA_W-1:0]   res,
  output logic                dst_sp,
  output logic [RIDX_W-1:0]   dst_idx,
  output logic                reg_we,
  output logic                flag_we,
  output logic [FLAG_W-1:0]   flags_out
);

  localparam int MSB = DATA_W - 1;

  stu_op_e           dec_op;
  logic [RIDX_W-1:0] dec_idx;
  logic [DATA_W-1:0] dec_imm;
  logic [DATA_W-1:0] minuend;
  logic [DATA_W-1:0] subtrahend;
  logic [DATA_W-1:0] alu_res;
  stu_flags_t        alu_flags;
  logic              alu_wr_reg;
  logic              alu_wr_flags;
  logic              alu_to_sp;
  logic              sub_carry;
  logic              sub_ovf;

  stu_decode #(.DATA_W(DATA_W)) u_dec (
    .instr   (instr),
    .op      (dec_op),
    .dst_idx (dec_idx),
    .imm     (dec_imm)
  );

  stu_opsel #(.DATA_W(DATA_W)) u_sel (
    .op         (dec_op),
    .rn_val     (rn_val),
    .rm_val     (rm_val),
    .rd_val     (rd_val),
    .sp_val     (sp_val),
    .imm        (dec_imm),
    .minuend    (minuend),
    .subtrahend (subtrahend)
  );

  stu_alu #(.DATA_W(DATA_W)) u_alu (
    .op         (dec_op),
    .minuend    (minuend),
    .subtrahend (subtrahend),
    .rn_val     (rn_val),
    .rm_val     (rm_val),
    .flags_in   (stu_flags_t'(flags_in)),
    .result     (alu_res),
    .flags_nx   (alu_flags),
    .wr_reg     (alu_wr_reg),
    .wr_flags   (alu_wr_flags),
    .to_sp      (alu_to_sp),
    .sub_carry  (sub_carry),
    .sub_ovf    (sub_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      dst_sp    <= 1'b0;
      dst_idx   <= '0;
      reg_we    <= 1'b0;
      flag_we   <= 1'b0;
      flags_out <= '0;
    end else if (in_valid) begin
      res       <= alu_res;
      dst_sp    <= alu_to_sp;
      dst_idx   <= dec_idx;
      reg_we    <= alu_wr_reg;
      flag_we   <= alu_wr_flags;
      flags_out <= alu_flags;
    end else begin
      reg_we    <= 1'b0;
      flag_we   <= 1'b0;
    end
  end

  // R9
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || flag_we) |-> $past(in_valid));

  // R7
  sp_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && dst_sp) |-> (!flag_we && flags_out == $past(flags_in)));

  // R8
  test_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !reg_we) |-> (flags_out[1:0] == $past(flags_in[1:0])));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flags_out[2] == (res == '0) && flags_out[3] == res[MSB]));

  // R5
  no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && reg_we) |-> (flags_out[1] == ($past(minuend) >= $past(subtrahend))));

  // R6
  signed_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && reg_we) |->
      (flags_out[0] == (($signed($past(minuend)) < $signed($past(subtrahend))) != res[MSB])));

endmodule

// File: tb/tb_stu_core.sv
module tb_stu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] rn_val = '0, rm_val = '0, rd_val = '0, sp_val = '0;
  logic [3:0]  flags_in = '0;
  logic [31:0] res;
  logic        dst_sp;
  logic [2:0]  dst_idx;
  logic        reg_we;
  logic        flag_we;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stu_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rn_val(rn_val), .rm_val(rm_val), .rd_val(rd_val), .sp_val(sp_val),
    .flags_in(flags_in), .res(res), .dst_sp(dst_sp), .dst_idx(dst_idx),
    .reg_we(reg_we), .flag_we(flag_we), .flags_out(flags_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference flags for a - b, from a 33-bit difference and a 64-bit signed difference
  function automatic logic [3:0] ref_sub_flags(input logic [31:0] a, input logic [31:0] b);
    logic [32:0]       w;
    longint            sd;
    logic              ov;
    w  = {1'b0, a} - {1'b0, b};
    sd = longint'($signed(a)) - longint'($signed(b));
    ov = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    return {w[31], (w[31:0] == 32'd0), ~w[32], ov};
  endfunction

  // apply one instruction; outputs are sampled one cycle later
  task automatic issue(input logic [15:0] ins, input logic [31:0] n, input logic [31:0] m,
                       input logic [31:0] d, input logic [31:0] s, input logic [3:0] f);
    @(negedge clk);
    instr = ins; rn_val = n; rm_val = m; rd_val = d; sp_val = s; flags_in = f;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sub_case(input string req, input logic [15:0] ins, input logic [31:0] a,
                          input logic [31:0] b, input logic [2:0] idx);
    chk(req, "res", res, a - b);
    chk(req, "reg_we", 32'(reg_we), 32'd1);
    chk(req, "flag_we", 32'(flag_we), 32'd1);
    chk(req, "dst_sp", 32'(dst_sp), 32'd0);
    chk(req, "dst_idx", 32'(dst_idx), 32'(idx));
    chk(req, "flags", 32'(flags_out), 32'(ref_sub_flags(a, b)));
  endtask

  task automatic t_reset;
    chk("R10", "res", res, 32'd0);
    chk("R10", "reg_we", 32'(reg_we), 32'd0);
    chk("R10", "flag_we", 32'(flag_we), 32'd0);
    chk("R10", "flags", 32'(flags_out), 32'd0);
  endtask

  task automatic t_imm3;
    issue({7'b0001111, 3'd3, 3'd1, 3'd5}, 32'd10, 32'hDEAD, 32'd0, 32'd0, 4'b0000);
    sub_case("R1", instr, 32'd10, 32'd3, 3'd5);
    issue({7'b0001111, 3'd7, 3'd2, 3'd0}, 32'd2, 32'd0, 32'd0, 32'd0, 4'b0000);
    sub_case("R1", instr, 32'd2, 32'd7, 3'd0);
  endtask

  task automatic t_imm8;
    issue({5'b00111, 3'd6, 8'hFF}, 32'd0, 32'd0, 32'h100, 32'd0, 4'b1111);
    sub_case("R2", instr, 32'h100, 32'hFF, 3'd6);
  endtask

  task automatic t_reg_bounds;
    // R5 R6 boundary patterns together with R3
    issue({7'b0001101, 3'd1, 3'd2, 3'd3}, 32'd0, 32'd0, 32'd0, 32'd0, 4'b0000);
    sub_case("R3_R4", instr, 32'd0, 32'd0, 3'd3);
    issue({7'b0001101, 3'd1, 3'd2, 3'd4}, 32'd0, 32'd1, 32'd0, 32'd0, 4'b0000);
    sub_case("R5", instr, 32'd0, 32'd1, 3'd4);
    issue({7'b0001101, 3'd1, 3'd2, 3'd7}, 32'h80000000, 32'd1, 32'd0, 32'd0, 4'b0000);
    sub_case("R6", instr, 32'h80000000, 32'd1, 3'd7);
    issue({7'b0001101, 3'd1, 3'd2, 3'd1}, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'd0, 32'd0, 4'b0000);
    sub_case("R6", instr, 32'h7FFFFFFF, 32'hFFFFFFFF, 3'd1);
  endtask

  task automatic t_sp;
    issue({9'b101100001, 7'd127}, 32'd0, 32'd0, 32'd0, 32'h1000, 4'b1010);
    chk("R7", "res", res, 32'h1000 - 32'd508);
    chk("R7", "dst_sp", 32'(dst_sp), 32'd1);
    chk("R7", "reg_we", 32'(reg_we), 32'd1);
    chk("R7", "flag_we", 32'(flag_we), 32'd0);
    chk("R7", "flags", 32'(flags_out), 32'hA);
  endtask

  task automatic t_test;
    issue({10'b0100001000, 3'd2, 3'd1}, 32'hF0F0_0000, 32'h0F0F_FFFF, 32'd0, 32'd0, 4'b0011);
    chk("R8", "reg_we", 32'(reg_we), 32'd0);
    chk("R8", "flag_we", 32'(flag_we), 32'd1);
    chk("R8", "flags", 32'(flags_out), 32'b0111);
    issue({10'b0100001000, 3'd2, 3'd1}, 32'h8000_0001, 32'hFFFF_0000, 32'd0, 32'd0, 4'b0100);
    chk("R8", "flags", 32'(flags_out), 32'b1000);
  endtask

  task automatic t_undef;
    issue(16'hFFFF, 32'd5, 32'd1, 32'd0, 32'd0, 4'b0110);
    chk("R9", "reg_we", 32'(reg_we), 32'd0);
    chk("R9", "flag_we", 32'(flag_we), 32'd0);
    chk("R9", "flags", 32'(flags_out), 32'b0110);
  endtask

  task automatic t_latency;
    issue({7'b0001101, 3'd1, 3'd2, 3'd2}, 32'd9, 32'd4, 32'd0, 32'd0, 4'b0000);
    chk("R11", "reg_we", 32'(reg_we), 32'd1);
    @(negedge clk);
    chk("R11", "reg_we idle", 32'(reg_we), 32'd0);
    chk("R9", "flag_we idle", 32'(flag_we), 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_imm3();
    t_imm8();
    t_reg_bounds();
    t_sp();
    t_test();
    t_undef();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule